// File: doc/BRIEF.md
# Miss-Tracking Entry Pool

This block holds the state of outstanding cache misses in a fixed pool of entries. Each entry carries a block address, a request size, the cycle at which it may first be issued, a logical sequence number and a count of merged targets. An entry is free, waiting on the issue list, or in service. The cache allocates an entry when a miss occurs and reads the head of the issue list to send requests downstream. It then moves entries between the list, service and the free pool as responses and retries arrive.

The issue list is kept as a rank per waiting entry, where rank 0 is the head. Commands can change that order. A promotion moves a waiting entry to the head. A delay pushes an entry's ready cycle later and moves every later-listed entry that is now due sooner ahead of it. Three status outputs drive allocation policy upstream: a full flag, a pending-work flag and a prefetch-permission flag. Prefetch permission keeps a second reserve of entries free for demand misses, on top of the general reserve.

At most one command executes per cycle. When several strobes are raised together, a fixed priority selects the winner and the others are dropped. All commands other than allocation use one shared entry index.

Top module: `miss_track_pool`

## Requirements
- R1: After reset every entry is free: `pending_o`=0, `full_o`=0, `prefetch_ok_o`=1, `issue_valid_o`=0 and `alloc_idx_o`=0.
- R2: Allocation takes the lowest-numbered free entry, which `alloc_idx_o` shows beforehand. The entry gets a target count of 1 and joins the tail of the issue list, so entries issue in allocation order. `issue_addr_o`, `issue_size_o` and `issue_order_o` show the head entry's stored fields.
- R3: `full_o` is high when the allocated count exceeds `NUM_ENT - GEN_RSV`. An allocation that wins arbitration while the pool is full raises `alloc_err_o` in that cycle and changes nothing.
- R4: `prefetch_ok_o` is high only when the allocated count is below `NUM_ENT - (GEN_RSV + 1 + DEM_RSV)`. With the default parameters that limit is 4.
- R5: `issue_valid_o` is high only when the list is non-empty and `now_i` is at or past the head entry's ready cycle. `issue_idx_o` then names the head entry.
- R6: A service command on a waiting entry removes it from the list. With `svc_resp_i`=1 the entry is held in service; with `svc_resp_i`=0 it is freed. A service command on an entry that is not waiting is ignored.
- R7: A pending command on an in-service entry puts it back at the tail of the issue list.
- R8: A promote command moves a waiting entry to the head of the list. On an in-service or free entry it has no effect on the list.
- R9: A delay command adds `delay_cyc_i` to the entry's ready cycle. If the entry is waiting, every entry listed behind it whose ready cycle is now earlier than its new ready cycle moves ahead of it.
- R10: `pending_o` is high exactly when at least one entry is on the issue list.
- R11: A merge command raises an allocated entry's target count by one, saturating. A force-deallocate command lowers it by one and frees the entry when it reaches zero. During a force-deallocate, `fd_not_full_o` shows whether the pool is not full once the command takes effect.
- R12: Strobe priority is free, then force-deallocate, then service, then pending, then promote, then delay, then merge, then allocate. Only the highest raised strobe is considered, even if it turns out to be ignored.
- R13: A free command releases any allocated entry, whether it is waiting or in service, and removes it from the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_i | input | TIME_W | Current cycle count |
| alloc_i | input | 1 | Allocate strobe |
| alloc_addr_i | input | ADDR_W | Block address for allocation |
| alloc_size_i | input | SIZE_W | Request size for allocation |
| alloc_ready_i | input | TIME_W | Earliest issue cycle for allocation |
| alloc_order_i | input | ORD_W | Logical sequence number for allocation |
| cmd_idx_i | input | IW | Entry index for non-allocate commands |
| free_i | input | 1 | Free strobe |
| fdealloc_i | input | 1 | Force-deallocate strobe |
| svc_i | input | 1 | Mark-in-service strobe |
| svc_resp_i | input | 1 | Entry expects a response |
| pend_i | input | 1 | Back-to-pending strobe |
| promote_i | input | 1 | Promote-to-head strobe |
| delay_i | input | 1 | Delay strobe |
| delay_cyc_i | input | TIME_W | Cycles added by a delay |
| merge_i | input | 1 | Add-target strobe |
| alloc_idx_o | output | IW | Entry the next allocation would take |
| alloc_err_o | output | 1 | Allocation attempted while full |
| fd_not_full_o | output | 1 | Pool not full after this force-deallocate |
| full_o | output | 1 | Pool full |
| pending_o | output | 1 | Issue list non-empty |
| prefetch_ok_o | output | 1 | Prefetch allocation permitted |
| issue_valid_o | output | 1 | Head entry may be issued now |
| issue_idx_o | output | IW | Head entry index |
| issue_addr_o | output | ADDR_W | Head entry block address |
| issue_size_o | output | SIZE_W | Head entry size |
| issue_order_o | output | ORD_W | Head entry sequence number |

## Verification
The checks assume that `now_i` never decreases and that ready cycles plus delays stay inside `TIME_W` without wrapping, because ready times are compared as plain unsigned values. They also assume that the allocation and status relations are only checked when `alloc_i` is the only strobe raised. The bench drives one command per cycle except in the priority scenario and keeps its time values small. Before each scenario it releases every entry with free commands, so every expected order starts from an empty list.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

   typedef enum logic [1:0] {
      ES_FREE = 2'd0,
      ES_PEND = 2'd1,
      ES_SVC  = 2'd2
   } ent_state_e;

   typedef enum logic [3:0] {
      OP_NONE  = 4'd0,
      OP_FREE  = 4'd1,
      OP_FDEAL = 4'd2,
      OP_SVC   = 4'd3,
      OP_PEND  = 4'd4,
      OP_PROM  = 4'd5,
      OP_DELAY = 4'd6,
      OP_MERGE = 4'd7,
      OP_ALLOC = 4'd8
   } op_e;

endpackage

// File: rtl/mtp_cmd_arb.sv
module mtp_cmd_arb
   import mtp_pkg::*;
(
   input  logic free_i,
   input  logic fdealloc_i,
   input  logic svc_i,
   input  logic pend_i,
   input  logic promote_i,
   input  logic delay_i,
   input  logic merge_i,
   input  logic alloc_i,
   output op_e  req_op_o
);
   // fixed priority: release paths first, allocation last
   always_comb begin
      if      (free_i)     req_op_o = OP_FREE;
      else if (fdealloc_i) req_op_o = OP_FDEAL;
      else if (svc_i)      req_op_o = OP_SVC;
      else if (pend_i)     req_op_o = OP_PEND;
      else if (promote_i)  req_op_o = OP_PROM;
      else if (delay_i)    req_op_o = OP_DELAY;
      else if (merge_i)    req_op_o = OP_MERGE;
      else if (alloc_i)    req_op_o = OP_ALLOC;
      else                 req_op_o = OP_NONE;
   end
endmodule

// File: rtl/mtp_entry.sv
module mtp_entry
   import mtp_pkg::*;
#(
   parameter int IW     = 3,
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 8,
   parameter int TIME_W = 16,
   parameter int ORD_W  = 16,
   parameter int TGT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  op_e               op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [SIZE_W-1:0] size_i,
   input  logic [TIME_W-1:0] ready_i,
   input  logic [ORD_W-1:0]  order_i,
   input  logic              resp_i,
   input  logic [TIME_W-1:0] dly_i,
   input  logic [IW-1:0]     tail_rank_i,
   input  logic [IW-1:0]     sel_rank_i,
   input  logic [IW-1:0]     dly_pos_i,
   input  logic              list_rm_i,
   input  logic              promote_i,
   input  logic              dly_move_i,
   output ent_state_e        state_o,
   output logic [IW-1:0]     rank_o,
   output logic [TIME_W-1:0] ready_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [SIZE_W-1:0] size_o,
   output logic [ORD_W-1:0]  order_o,
   output logic [TGT_W-1:0]  tgt_o
);
   localparam logic [TGT_W-1:0] TGT_ONE = TGT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_o <= ES_FREE;
         rank_o  <= '0;
         ready_o <= '0;
         addr_o  <= '0;
         size_o  <= '0;
         order_o <= '0;
         tgt_o   <= '0;
      end else if (sel_i) begin
         unique case (op_i)
            OP_ALLOC: begin
               state_o <= ES_PEND;
               rank_o  <= tail_rank_i;
               ready_o <= ready_i;
               addr_o  <= addr_i;
               size_o  <= size_i;
               order_o <= order_i;
               tgt_o   <= TGT_ONE;
            end
            OP_FREE: begin
               state_o <= ES_FREE;
               tgt_o   <= '0;
            end
            OP_FDEAL: begin
               if (tgt_o <= TGT_ONE) begin
                  state_o <= ES_FREE;
                  tgt_o   <= '0;
               end else begin
                  tgt_o <= tgt_o - TGT_ONE;
               end
            end
            OP_SVC:   state_o <= resp_i ? ES_SVC : ES_FREE;
            OP_PEND: begin
               state_o <= ES_PEND;
               rank_o  <= tail_rank_i;
            end
            OP_PROM:  rank_o <= '0;
            OP_DELAY: begin
               ready_o <= ready_o + dly_i;
               if (state_o == ES_PEND) rank_o <= dly_pos_i;
            end
            OP_MERGE: tgt_o <= tgt_o + TGT_ONE;
            default: ;
         endcase
      end else if (state_o == ES_PEND) begin
         // neighbours shift to keep the ranks dense
         if (list_rm_i && rank_o > sel_rank_i)
            rank_o <= rank_o - IW'(1);
         else if (promote_i && rank_o < sel_rank_i)
            rank_o <= rank_o + IW'(1);
         else if (dly_move_i && rank_o > sel_rank_i && rank_o <= dly_pos_i)
            rank_o <= rank_o - IW'(1);
      end
   end
endmodule

// File: rtl/mtp_issue.sv
module mtp_issue
   import mtp_pkg::*;
#(
   parameter int N         = 8,
   parameter int IW        = 3,
   parameter int TIME_W    = 16,
   parameter bit GATE_TIME = 1'b1
) (
   input  ent_state_e [N-1:0]             st_a,
   input  logic       [N-1:0][IW-1:0]     rk_a,
   input  logic       [N-1:0][TIME_W-1:0] rd_a,
   input  logic       [TIME_W-1:0]        now_i,
   output logic       [N-1:0]             head_vec_o,
   output logic       [IW-1:0]            head_idx_o,
   output logic                           issue_ok_o
);
   logic found;

   always_comb begin
      head_idx_o = '0;
      found      = 1'b0;
      for (int i = 0; i < N; i++) begin
         head_vec_o[i] = (st_a[i] == ES_PEND) && (rk_a[i] == '0);
         if (head_vec_o[i]) begin
            head_idx_o = IW'(i);
            found      = 1'b1;
         end
      end
   end

   generate
      if (GATE_TIME) begin : g_timed
         assign issue_ok_o = found && (now_i >= rd_a[head_idx_o]);
      end else begin : g_untimed
         logic [TIME_W-1:0] unused_now;
         assign unused_now = now_i ^ rd_a[head_idx_o];
         assign issue_ok_o = found;
      end
   endgenerate
endmodule

// File: rtl/miss_track_pool.sv
module miss_track_pool
   import mtp_pkg::*;
#(
   parameter int NUM_ENT   = 8,
   parameter int GEN_RSV   = 1,
   parameter int DEM_RSV   = 2,
   parameter int ADDR_W    = 32,
   parameter int SIZE_W    = 8,
   parameter int TIME_W    = 16,
   parameter int ORD_W     = 16,
   parameter int TGT_W     = 3,
   parameter bit GATE_TIME = 1'b1,
   localparam int IW       = $clog2(NUM_ENT),
   localparam int CW       = $clog2(NUM_ENT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now_i,
   input  logic              alloc_i,
   input  logic [ADDR_W-1:0] alloc_addr_i,
   input  logic [SIZE_W-1:0] alloc_size_i,
   input  logic [TIME_W-1:0] alloc_ready_i,
   input  logic [ORD_W-1:0]  alloc_order_i,
   input  logic [IW-1:0]     cmd_idx_i,
   input  logic              free_i,
   input  logic              fdealloc_i,
   input  logic              svc_i,
   input  logic              svc_resp_i,
   input  logic              pend_i,
   input  logic              promote_i,
   input  logic              delay_i,
   input  logic [TIME_W-1:0] delay_cyc_i,
   input  logic              merge_i,
   output logic [IW-1:0]     alloc_idx_o,
   output logic              alloc_err_o,
   output logic              fd_not_full_o,
   output logic              full_o,
   output logic              pending_o,
   output logic              prefetch_ok_o,
   output logic              issue_valid_o,
   output logic [IW-1:0]     issue_idx_o,
   output logic [ADDR_W-1:0] issue_addr_o,
   output logic [SIZE_W-1:0] issue_size_o,
   output logic [ORD_W-1:0]  issue_order_o
);
   localparam int N = NUM_ENT;
   localparam logic [CW-1:0] FULL_LIM = CW'(NUM_ENT - GEN_RSV);
   localparam logic [CW-1:0] PF_LIM   = CW'(NUM_ENT - (GEN_RSV + 1 + DEM_RSV));
   localparam logic [IW:0]   IDX_LIM  = (IW+1)'(NUM_ENT);

   generate
      if (NUM_ENT < 2) begin : g_bad_n
         $error("miss_track_pool: NUM_ENT must be at least 2");
      end
      if (GEN_RSV < 0 || DEM_RSV < 0) begin : g_bad_rsv
         $error("miss_track_pool: reserves must not be negative");
      end
      if (NUM_ENT <= GEN_RSV + 1 + DEM_RSV) begin : g_bad_pf
         $error("miss_track_pool: reserves leave no room for prefetch");
      end
      if (TGT_W < 1) begin : g_bad_tgt
         $error("miss_track_pool: TGT_W must be at least 1");
      end
   endgenerate

   ent_state_e [N-1:0]             st_a;
   logic       [N-1:0][IW-1:0]     rk_a;
   logic       [N-1:0][TIME_W-1:0] rd_a;
   logic       [N-1:0][ADDR_W-1:0] ad_a;
   logic       [N-1:0][SIZE_W-1:0] sz_a;
   logic       [N-1:0][ORD_W-1:0]  od_a;
   logic       [N-1:0][TGT_W-1:0]  tg_a;
   logic       [N-1:0]             head_vec;

   op_e               req_op, eff_op;
   logic [CW-1:0]     n_alloc, n_pend, n_after;
   logic [IW-1:0]     free_idx, tgt_idx, dly_pos;
   logic              has_free, idx_ok, op_ok, fd_frees;
   logic              list_rm, prom_go, dly_move;
   ent_state_e        sel_st;
   logic [IW-1:0]     sel_rank;
   logic [TIME_W-1:0] dly_new;
   logic [TGT_W-1:0]  sel_tgt;

   mtp_cmd_arb u_arb (
      .free_i    (free_i),
      .fdealloc_i(fdealloc_i),
      .svc_i     (svc_i),
      .pend_i    (pend_i),
      .promote_i (promote_i),
      .delay_i   (delay_i),
      .merge_i   (merge_i),
      .alloc_i   (alloc_i),
      .req_op_o  (req_op)
   );

   // occupancy counts and lowest free entry
   always_comb begin
      n_alloc  = '0;
      n_pend   = '0;
      free_idx = '0;
      has_free = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (st_a[i] != ES_FREE) n_alloc = n_alloc + CW'(1);
         if (st_a[i] == ES_PEND) n_pend  = n_pend + CW'(1);
         if (st_a[i] == ES_FREE) begin
            free_idx = IW'(i);
            has_free = 1'b1;
         end
      end
   end

   assign full_o        = n_alloc > FULL_LIM;
   assign prefetch_ok_o = n_alloc < PF_LIM;
   assign pending_o     = n_pend != '0;
   assign alloc_idx_o   = free_idx;

   assign idx_ok   = {1'b0, cmd_idx_i} < IDX_LIM;
   assign sel_st   = st_a[cmd_idx_i];
   assign sel_rank = rk_a[cmd_idx_i];
   assign sel_tgt  = tg_a[cmd_idx_i];
   assign fd_frees = sel_tgt <= TGT_W'(1);

   // legality of the winning command against the addressed entry
   always_comb begin
      unique case (req_op)
         OP_FREE, OP_FDEAL, OP_DELAY: op_ok = idx_ok && sel_st != ES_FREE;
         OP_SVC, OP_PROM:             op_ok = idx_ok && sel_st == ES_PEND;
         OP_PEND:                     op_ok = idx_ok && sel_st == ES_SVC;
         OP_MERGE: op_ok = idx_ok && sel_st != ES_FREE && sel_tgt != '1;
         OP_ALLOC:                    op_ok = !full_o && has_free;
         default:                     op_ok = 1'b0;
      endcase
   end

   assign eff_op  = op_ok ? req_op : OP_NONE;
   assign tgt_idx = (req_op == OP_ALLOC) ? free_idx : cmd_idx_i;

   assign list_rm  = sel_st == ES_PEND &&
                     (eff_op == OP_FREE || eff_op == OP_SVC ||
                      (eff_op == OP_FDEAL && fd_frees));
   assign prom_go  = eff_op == OP_PROM;
   assign dly_move = eff_op == OP_DELAY && sel_st == ES_PEND;

   // delay: land behind the last listed-later entry now due sooner
   always_comb begin
      dly_new = rd_a[cmd_idx_i] + delay_cyc_i;
      dly_pos = sel_rank;
      for (int j = 0; j < N; j++) begin
         if (st_a[j] == ES_PEND && rk_a[j] > sel_rank &&
             rd_a[j] < dly_new && rk_a[j] > dly_pos)
            dly_pos = rk_a[j];
      end
   end

   assign n_after       = n_alloc - ((eff_op == OP_FDEAL && fd_frees) ? CW'(1) : CW'(0));
   assign fd_not_full_o = eff_op == OP_FDEAL && !(n_after > FULL_LIM);
   assign alloc_err_o   = req_op == OP_ALLOC && full_o;

   generate
      for (genvar g = 0; g < N; g++) begin : g_ent
         mtp_entry #(
            .IW(IW), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
            .TIME_W(TIME_W), .ORD_W(ORD_W), .TGT_W(TGT_W)
         ) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel_i      (eff_op != OP_NONE && tgt_idx == IW'(g)),
            .op_i       (eff_op),
            .addr_i     (alloc_addr_i),
            .size_i     (alloc_size_i),
            .ready_i    (alloc_ready_i),
            .order_i    (alloc_order_i),
            .resp_i     (svc_resp_i),
            .dly_i      (delay_cyc_i),
            .tail_rank_i(IW'(n_pend)),
            .sel_rank_i (sel_rank),
            .dly_pos_i  (dly_pos),
            .list_rm_i  (list_rm),
            .promote_i  (prom_go),
            .dly_move_i (dly_move),
            .state_o    (st_a[g]),
            .rank_o     (rk_a[g]),
            .ready_o    (rd_a[g]),
            .addr_o     (ad_a[g]),
            .size_o     (sz_a[g]),
            .order_o    (od_a[g]),
            .tgt_o      (tg_a[g])
         );
      end
   endgenerate

   mtp_issue #(
      .N(N), .IW(IW), .TIME_W(TIME_W), .GATE_TIME(GATE_TIME)
   ) u_issue (
      .st_a      (st_a),
      .rk_a      (rk_a),
      .rd_a      (rd_a),
      .now_i     (now_i),
      .head_vec_o(head_vec),
      .head_idx_o(issue_idx_o),
      .issue_ok_o(issue_valid_o)
   );

   assign issue_addr_o  = ad_a[issue_idx_o];
   assign issue_size_o  = sz_a[issue_idx_o];
   assign issue_order_o = od_a[issue_idx_o];

endmodule

// File: rtl/mtp_chk.sv
module mtp_chk #(
   parameter int N  = 8,
   parameter int CW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          alloc_i,
   input logic          free_i,
   input logic          fdealloc_i,
   input logic          svc_i,
   input logic          pend_i,
   input logic          promote_i,
   input logic          delay_i,
   input logic          merge_i,
   input logic          full_o,
   input logic          pending_o,
   input logic          prefetch_ok_o,
   input logic          issue_valid_o,
   input logic [CW-1:0] n_alloc,
   input logic [CW-1:0] n_pend,
   input logic [N-1:0]  head_vec
);
   logic alloc_only;
   assign alloc_only = alloc_i && !(free_i || fdealloc_i || svc_i || pend_i ||
                                    promote_i || delay_i || merge_i);

   assert_issue_needs_list_R5: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid_o |-> pending_o);

   assert_pf_below_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      prefetch_ok_o |-> !full_o);

   assert_no_alloc_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_only && full_o) |=> (n_alloc == $past(n_alloc)));

   assert_alloc_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_only && !full_o && n_alloc < CW'(N)) |=> (n_alloc == $past(n_alloc) + CW'(1)));

   assert_pend_within_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      n_pend <= n_alloc);

   assert_single_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(head_vec));

   assert_head_iff_list_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (n_pend != '0) == (head_vec != '0));

endmodule

bind miss_track_pool mtp_chk #(.N(N), .CW(CW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .alloc_i      (alloc_i),
   .free_i       (free_i),
   .fdealloc_i   (fdealloc_i),
   .svc_i        (svc_i),
   .pend_i       (pend_i),
   .promote_i    (promote_i),
   .delay_i      (delay_i),
   .merge_i      (merge_i),
   .full_o       (full_o),
   .pending_o    (pending_o),
   .prefetch_ok_o(prefetch_ok_o),
   .issue_valid_o(issue_valid_o),
   .n_alloc      (n_alloc),
   .n_pend       (n_pend),
   .head_vec     (head_vec)
);

// File: tb/tb_miss_track_pool.sv
module tb_miss_track_pool;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] now_i = '0;
   logic        alloc_i = 1'b0;
   logic [31:0] alloc_addr_i = '0;
   logic [7:0]  alloc_size_i = '0;
   logic [15:0] alloc_ready_i = '0;
   logic [15:0] alloc_order_i = '0;
   logic [2:0]  cmd_idx_i = '0;
   logic        free_i = 1'b0, fdealloc_i = 1'b0, svc_i = 1'b0, svc_resp_i = 1'b0;
   logic        pend_i = 1'b0, promote_i = 1'b0, delay_i = 1'b0, merge_i = 1'b0;
   logic [15:0] delay_cyc_i = '0;
   logic [2:0]  alloc_idx_o, issue_idx_o;
   logic        alloc_err_o, fd_not_full_o, full_o, pending_o, prefetch_ok_o, issue_valid_o;
   logic [31:0] issue_addr_o;
   logic [7:0]  issue_size_o;
   logic [15:0] issue_order_o;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   miss_track_pool dut (
      .clk(clk), .rst_n(rst_n), .now_i(now_i),
      .alloc_i(alloc_i), .alloc_addr_i(alloc_addr_i), .alloc_size_i(alloc_size_i),
      .alloc_ready_i(alloc_ready_i), .alloc_order_i(alloc_order_i),
      .cmd_idx_i(cmd_idx_i), .free_i(free_i), .fdealloc_i(fdealloc_i),
      .svc_i(svc_i), .svc_resp_i(svc_resp_i), .pend_i(pend_i),
      .promote_i(promote_i), .delay_i(delay_i), .delay_cyc_i(delay_cyc_i),
      .merge_i(merge_i), .alloc_idx_o(alloc_idx_o), .alloc_err_o(alloc_err_o),
      .fd_not_full_o(fd_not_full_o), .full_o(full_o), .pending_o(pending_o),
      .prefetch_ok_o(prefetch_ok_o), .issue_valid_o(issue_valid_o),
      .issue_idx_o(issue_idx_o), .issue_addr_o(issue_addr_o),
      .issue_size_o(issue_size_o), .issue_order_o(issue_order_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // strobes are set at a falling edge; the rising edge in between applies them
   task automatic step();
      @(negedge clk);
      {alloc_i, free_i, fdealloc_i, svc_i, pend_i, promote_i, delay_i, merge_i} = '0;
   endtask

   task automatic do_alloc(input logic [31:0] a, input logic [15:0] rdy, input logic [15:0] ord);
      alloc_i = 1'b1; alloc_addr_i = a; alloc_size_i = a[7:0] + 8'd4;
      alloc_ready_i = rdy; alloc_order_i = ord;
      step();
   endtask

   task automatic do_svc(input int i, input bit resp);
      svc_i = 1'b1; cmd_idx_i = 3'(i); svc_resp_i = resp; step();
   endtask
   task automatic do_pend(input int i);  pend_i = 1'b1; cmd_idx_i = 3'(i); step(); endtask
   task automatic do_prom(input int i);  promote_i = 1'b1; cmd_idx_i = 3'(i); step(); endtask
   task automatic do_free(input int i);  free_i = 1'b1; cmd_idx_i = 3'(i); step(); endtask
   task automatic do_merge(input int i); merge_i = 1'b1; cmd_idx_i = 3'(i); step(); endtask
   task automatic do_dly(input int i, input int d);
      delay_i = 1'b1; cmd_idx_i = 3'(i); delay_cyc_i = 16'(d); step();
   endtask

   task automatic clean();
      for (int i = 0; i < N; i++) do_free(i);
   endtask

   task automatic t_reset();
      chk("R1 pending", pending_o, 0);
      chk("R1 full", full_o, 0);
      chk("R1 prefetch", prefetch_ok_o, 1);
      chk("R1 issue_valid", issue_valid_o, 0);
      chk("R1 alloc_idx", alloc_idx_o, 0);
   endtask

   task automatic t_alloc_order();
      now_i = 16'd50;
      do_alloc(32'h100, 0, 5);
      do_alloc(32'h200, 0, 6);
      do_alloc(32'h300, 0, 7);
      chk("R10 pending", pending_o, 1);
      chk("R2 head idx", issue_idx_o, 0);
      chk("R2 head addr", issue_addr_o, 32'h100);
      chk("R2 head size", issue_size_o, 8'h04);
      chk("R2 head order", issue_order_o, 5);
      do_svc(0, 1'b1);
      chk("R6 next head", issue_idx_o, 1);
      do_svc(1, 1'b0);
      chk("R6 no-resp frees", alloc_idx_o, 1);
      chk("R6 head after", issue_idx_o, 2);
      do_svc(2, 1'b1);
      chk("R10 empty list", pending_o, 0);
      chk("R5 no issue", issue_valid_o, 0);
      do_pend(0);
      chk("R7 back on list", pending_o, 1);
      chk("R7 head", issue_idx_o, 0);
      clean();
   endtask

   task automatic t_ready_time();
      now_i = 16'd10;
      do_alloc(32'h400, 20, 1);
      chk("R5 not yet", issue_valid_o, 0);
      chk("R10 listed", pending_o, 1);
      now_i = 16'd20;
      #1;
      chk("R5 due", issue_valid_o, 1);
      clean();
   endtask

   task automatic t_full();
      now_i = 16'd100;
      for (int i = 0; i < 3; i++) do_alloc(32'h1000 + 32'(i), 0, 16'(i));
      chk("R4 three allocated", prefetch_ok_o, 1);
      do_alloc(32'h1003, 0, 3);
      chk("R4 four allocated", prefetch_ok_o, 0);
      for (int i = 4; i < 7; i++) do_alloc(32'h1000 + 32'(i), 0, 16'(i));
      chk("R3 seven not full", full_o, 0);
      do_alloc(32'h1007, 0, 7);
      chk("R3 eight full", full_o, 1);
      do_merge(5);
      fdealloc_i = 1'b1; cmd_idx_i = 3'd5;
      #1;
      chk("R11 still full flag", fd_not_full_o, 0);
      step();
      chk("R11 entry kept", full_o, 1);
      alloc_i = 1'b1;
      #1;
      chk("R3 alloc error", alloc_err_o, 1);
      step();
      chk("R3 still full", full_o, 1);
      fdealloc_i = 1'b1; cmd_idx_i = 3'd0;
      #1;
      chk("R11 unfull flag", fd_not_full_o, 1);
      step();
      chk("R11 freed", full_o, 0);
      chk("R11 free idx", alloc_idx_o, 0);
      clean();
   endtask

   task automatic t_promote();
      now_i = 16'd100;
      do_alloc(32'h10, 0, 0);
      do_alloc(32'h20, 0, 1);
      do_alloc(32'h30, 0, 2);
      do_prom(2);
      chk("R8 promoted head", issue_idx_o, 2);
      do_svc(2, 1'b1);
      do_prom(2);
      chk("R8 ignored on svc", issue_idx_o, 0);
      do_pend(2);
      do_svc(0, 1'b1);
      do_svc(1, 1'b1);
      chk("R7 tail order", issue_idx_o, 2);
      clean();
   endtask

   task automatic t_delay();
      now_i = 16'd25;
      do_alloc(32'h50, 0, 0);
      do_alloc(32'h60, 10, 1);
      do_alloc(32'h70, 50, 2);
      do_dly(0, 30);
      chk("R9 earlier moves ahead", issue_idx_o, 1);
      do_svc(1, 1'b1);
      chk("R9 delayed head", issue_idx_o, 0);
      chk("R9 delayed not due", issue_valid_o, 0);
      now_i = 16'd30;
      #1;
      chk("R9 delayed due", issue_valid_o, 1);
      do_svc(0, 1'b1);
      chk("R9 last head", issue_idx_o, 2);
      clean();
   endtask

   task automatic t_targets();
      now_i = 16'd100;
      do_alloc(32'h80, 0, 0);
      do_merge(0);
      do_merge(0);
      fdealloc_i = 1'b1; cmd_idx_i = 3'd0; step();
      fdealloc_i = 1'b1; cmd_idx_i = 3'd0; step();
      chk("R11 targets left", pending_o, 1);
      fdealloc_i = 1'b1; cmd_idx_i = 3'd0; step();
      chk("R11 last target frees", pending_o, 0);
      clean();
   endtask

   task automatic t_priority();
      now_i = 16'd100;
      do_alloc(32'h90, 0, 0);
      do_alloc(32'hA0, 0, 1);
      svc_i = 1'b1; promote_i = 1'b1; alloc_i = 1'b1; cmd_idx_i = 3'd0; svc_resp_i = 1'b1;
      step();
      chk("R12 svc wins head", issue_idx_o, 1);
      chk("R12 alloc dropped", alloc_idx_o, 2);
      free_i = 1'b1; svc_i = 1'b1; cmd_idx_i = 3'd1; svc_resp_i = 1'b1;
      step();
      chk("R13 free wins", alloc_idx_o, 1);
      chk("R13 list empty", pending_o, 0);
      pend_i = 1'b1; promote_i = 1'b1; cmd_idx_i = 3'd0;
      step();
      chk("R12 pend wins", pending_o, 1);
      do_free(0);
      chk("R13 svc entry freed", alloc_idx_o, 0);
      clean();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      @(negedge clk);
      t_alloc_order();
      t_ready_time();
      t_full();
      t_promote();
      t_delay();
      t_targets();
      t_priority();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule